// File: doc/BRIEF.md
# System-Call Vector Redirect

This block sits between a CPU address bus and memory. It turns the operand of the coprocessor software-interrupt instruction into a direct system-call dispatch. When the CPU fetches that opcode, the block records the one-byte call number that the CPU reads in the next bus cycle. It then waits for the CPU to fetch the software-interrupt vector.

During that vector fetch, the address presented to memory is replaced by an entry in a two-byte-per-entry handler table, indexed by the recorded number. The CPU therefore loads the handler address for that particular call without running any decode routine. The table sits in the boot image area, below the vector page.

The substitution is combinational, so it applies in the same bus cycle as the vector fetch. All other cycles pass the CPU address through unchanged. A different vector being fetched while a call number is pending cancels the pending redirect.

Top module: `sysc_vec_redirect`

## Requirements
- R1: After reset no redirect is pending: a read of the software-interrupt vector ($00FFE4 or $00FFF4) passes through with mem_addr equal to cpu_addr.
- R2: An opcode-fetch read (op_fetch=1, cpu_rd=1) whose data is $02 arms the trap. The very next cycle, if it is a read with op_fetch=0 and vec_pull=0, captures cpu_data as the call number.
- R3: If the cycle after an arming opcode fetch is not such a plain read (for example, a write), the trap disarms and no number is captured.
- R4: While a number N is held, a vector-pull read of the low vector byte, at $00FFE4 (native) or $00FFF4 (emulation), drives mem_addr = TABLE_BASE + 2*N in that same cycle. TABLE_BASE defaults to $00FC00.
- R5: In the cycle directly after a redirected low byte, a vector-pull read of the high byte of the same vector (low address + 1) drives mem_addr = TABLE_BASE + 2*N + 1. The trap is then idle again, and a further vector read passes through.
- R6: A vector-pull read of any other address while a number is held (for example the IRQ vector at $00FFEE) passes through and cancels the pending redirect.
- R7: A high-byte vector read passes through unchanged in three cases: it does not directly follow a redirected low byte, it belongs to the other vector flavour, or no redirect is in progress.
- R8: Every cycle with vec_pull=0 passes cpu_addr to mem_addr unchanged. This includes the opcode fetch, the operand read and the stack writes.
- R9: An opcode fetch of any value other than $02 while a number is held cancels it. An opcode fetch of $02 in that state re-arms the trap, and the new operand replaces the old number.
- R10: An opcode fetch of any value other than $02 does not arm the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | AW (24) | Address driven by the CPU |
| cpu_data | input | DW (8) | Data bus value in the current cycle |
| op_fetch | input | 1 | High during an opcode fetch cycle |
| vec_pull | input | 1 | High during an interrupt vector fetch cycle |
| cpu_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| mem_addr | output | AW (24) | Address presented to memory, possibly substituted |

## Verification
The assertions assume that every rising clock edge ends exactly one bus cycle. They also assume that op_fetch and vec_pull are never high together, and that the CPU fetches a vector's high byte in the cycle right after its low byte. Under these assumptions, the sequencer state after a vector or opcode cycle is fully determined. The stimulus drives one complete bus cycle per clock from a single task, always asserting at most one strobe. Broken sequences, such as a gap between the two vector bytes or a mismatched flavour, are used only to check that the address is passed through.

// File: rtl/sysc_trap_pkg.sv
package sysc_trap_pkg;

  // Sequencer states of the redirect trap.
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,  // nothing pending
    ST_GOT_OP   = 2'd1,  // trap opcode seen, operand expected next
    ST_SIG_HELD = 2'd2,  // call number held, waiting for the vector fetch
    ST_HI_PEND  = 2'd3   // low byte redirected, high byte expected next
  } trap_st_e;

  // Defaults shared by the top and the bench-facing documentation.
  localparam int unsigned DEF_AW = 24;
  localparam int unsigned DEF_DW = 8;

endpackage

// File: rtl/sysc_bus_decode.sv
module sysc_bus_decode #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 8,
  parameter int unsigned NVEC = 2,
  parameter logic [DW-1:0] COP_OP = 8'h02,
  parameter logic [NVEC*AW-1:0] VEC_LIST = {24'h00FFF4, 24'h00FFE4}
) (
  input  logic [AW-1:0]   cpu_addr,
  input  logic [DW-1:0]   cpu_data,
  input  logic            op_fetch,
  input  logic            vec_pull,
  input  logic            cpu_rd,
  output logic            cop_fetch,
  output logic            other_fetch,
  output logic            operand_rd,
  output logic            vec_rd,
  output logic [NVEC-1:0] lo_hit,
  output logic [NVEC-1:0] hi_hit
);

  logic fetch_rd;

  always_comb begin
    fetch_rd    = op_fetch & cpu_rd;
    cop_fetch   = fetch_rd & (cpu_data == COP_OP);
    other_fetch = fetch_rd & (cpu_data != COP_OP);
    operand_rd  = cpu_rd & ~op_fetch & ~vec_pull;
    vec_rd      = vec_pull & cpu_rd;
  end

  // One comparator pair per supported vector flavour.
  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    localparam logic [AW-1:0] LO_A = VEC_LIST[g*AW +: AW];
    localparam logic [AW-1:0] HI_A = LO_A + AW'(1);
    assign lo_hit[g] = vec_rd & (cpu_addr == LO_A);
    assign hi_hit[g] = vec_rd & (cpu_addr == HI_A);
  end

endmodule

// File: rtl/sysc_trap_fsm.sv
module sysc_trap_fsm
  import sysc_trap_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned NVEC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   cpu_data,
  input  logic            cop_fetch,
  input  logic            other_fetch,
  input  logic            operand_rd,
  input  logic            vec_rd,
  input  logic [NVEC-1:0] lo_hit,
  input  logic [NVEC-1:0] hi_hit,
  output logic [DW-1:0]   sig_q,
  output logic            remap_lo,
  output logic            remap_hi
);

  trap_st_e        st_q, st_d;
  logic [NVEC-1:0] flav_q;

  // Substitution enables for the current bus cycle.
  always_comb begin
    remap_lo = (st_q == ST_SIG_HELD) & (|lo_hit);
    remap_hi = (st_q == ST_HI_PEND) & (|(hi_hit & flav_q));
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cop_fetch) st_d = ST_GOT_OP;
      end
      ST_GOT_OP: begin
        if (operand_rd)     st_d = ST_SIG_HELD;
        else if (cop_fetch) st_d = ST_GOT_OP;
        else                st_d = ST_IDLE;
      end
      ST_SIG_HELD: begin
        if (remap_lo)         st_d = ST_HI_PEND;
        else if (vec_rd)      st_d = ST_IDLE;
        else if (cop_fetch)   st_d = ST_GOT_OP;
        else if (other_fetch) st_d = ST_IDLE;
      end
      ST_HI_PEND: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sig_q  <= '0;
      flav_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_GOT_OP && operand_rd) sig_q <= cpu_data;
      if (remap_lo) flav_q <= lo_hit;
    end
  end

  // R1: reset leaves the sequencer idle
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> st_q == ST_IDLE);

  // R2: operand after the trap opcode is captured
  assert_sig_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GOT_OP && operand_rd) |=> (sig_q == $past(cpu_data)) && st_q == ST_SIG_HELD);

  // R3: no plain read after the opcode disarms
  assert_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GOT_OP && !operand_rd && !cop_fetch) |=> st_q == ST_IDLE);

  // R5: high-byte redirect only straight after a low-byte redirect, then idle
  assert_hi_after_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    remap_hi |-> $past(remap_lo));
  assert_idle_after_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    remap_hi |=> st_q == ST_IDLE);

  // R6: a foreign vector cancels the pending call number
  assert_foreign_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SIG_HELD && vec_rd && !(|lo_hit)) |=> st_q == ST_IDLE);

  // R9: an unrelated opcode fetch cancels the pending call number
  assert_fetch_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SIG_HELD && other_fetch) |=> st_q == ST_IDLE);

endmodule

// File: rtl/sysc_addr_mux.sv
module sysc_addr_mux #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] TABLE_BASE = 24'h00FC00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] sig,
  input  logic          remap_lo,
  input  logic          remap_hi,
  output logic [AW-1:0] mem_addr
);

  // Handler table entry: two bytes per call number, low byte first.
  function automatic logic [AW-1:0] entry_addr(input logic [DW-1:0] num,
                                               input logic hi_byte);
    return TABLE_BASE + (AW'(num) << 1) + AW'(hi_byte);
  endfunction

  always_comb begin
    if (remap_lo)      mem_addr = entry_addr(sig, 1'b0);
    else if (remap_hi) mem_addr = entry_addr(sig, 1'b1);
    else               mem_addr = cpu_addr;
  end

  // R5: the high-byte redirect lands one byte above the low-byte redirect
  assert_hi_adjacent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    remap_hi |-> mem_addr == $past(mem_addr) + AW'(1));

  // R4: a low-byte redirect never lands on the vector address itself
  assert_lo_moved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    remap_lo |-> mem_addr != cpu_addr);

endmodule

// File: rtl/sysc_vec_redirect.sv
module sysc_vec_redirect #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] COP_OP = 8'h02,
  parameter logic [AW-1:0] VEC_NATIVE = 24'h00FFE4,
  parameter logic [AW-1:0] VEC_EMU = 24'h00FFF4,
  parameter logic [AW-1:0] TABLE_BASE = 24'h00FC00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          op_fetch,
  input  logic          vec_pull,
  input  logic          cpu_rd,
  output logic [AW-1:0] mem_addr
);

  localparam int unsigned NVEC = 2;
  localparam logic [NVEC*AW-1:0] VEC_LIST = {VEC_EMU, VEC_NATIVE};

  logic            cop_fetch, other_fetch, operand_rd, vec_rd;
  logic [NVEC-1:0] lo_hit, hi_hit;
  logic [DW-1:0]   sig_q;
  logic            remap_lo, remap_hi;

  sysc_bus_decode #(
    .AW(AW), .DW(DW), .NVEC(NVEC), .COP_OP(COP_OP), .VEC_LIST(VEC_LIST)
  ) u_decode (
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .op_fetch   (op_fetch),
    .vec_pull   (vec_pull),
    .cpu_rd     (cpu_rd),
    .cop_fetch  (cop_fetch),
    .other_fetch(other_fetch),
    .operand_rd (operand_rd),
    .vec_rd     (vec_rd),
    .lo_hit     (lo_hit),
    .hi_hit     (hi_hit)
  );

  sysc_trap_fsm #(
    .DW(DW), .NVEC(NVEC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_data   (cpu_data),
    .cop_fetch  (cop_fetch),
    .other_fetch(other_fetch),
    .operand_rd (operand_rd),
    .vec_rd     (vec_rd),
    .lo_hit     (lo_hit),
    .hi_hit     (hi_hit),
    .sig_q      (sig_q),
    .remap_lo   (remap_lo),
    .remap_hi   (remap_hi)
  );

  sysc_addr_mux #(
    .AW(AW), .DW(DW), .TABLE_BASE(TABLE_BASE)
  ) u_mux (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_addr(cpu_addr),
    .sig     (sig_q),
    .remap_lo(remap_lo),
    .remap_hi(remap_hi),
    .mem_addr(mem_addr)
  );

  // R8: cycles that are not vector fetches are never altered
  assert_plain_cycles_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_pull |-> mem_addr == cpu_addr);

  // R7: a high-byte vector fetch with no redirect in progress passes through
  assert_stray_hi_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_pull && !$past(remap_lo)) |-> (mem_addr == cpu_addr || |lo_hit));

endmodule

// File: tb/sysc_vec_redirect_tb.sv
`timescale 1ns/1ps
module sysc_vec_redirect_tb;

  localparam logic [23:0] TBL  = 24'h00FC00;
  localparam logic [23:0] VN   = 24'h00FFE4;
  localparam logic [23:0] VE   = 24'h00FFF4;
  localparam logic [23:0] VIRQ = 24'h00FFEE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        op_fetch = 1'b0;
  logic        vec_pull = 1'b0;
  logic        cpu_rd = 1'b1;
  logic [23:0] mem_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  sysc_vec_redirect u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .op_fetch(op_fetch), .vec_pull(vec_pull), .cpu_rd(cpu_rd), .mem_addr(mem_addr)
  );

  // Expected handler-table address, written independently of the design.
  function automatic logic [23:0] tbl_entry(input int num, input int hi);
    return TBL + 24'(num * 2 + hi);
  endfunction

  // Driver: one bus cycle per call, expected address pushed to the scoreboard.
  task automatic cyc(input logic [23:0] a, input logic [7:0] d, input logic opf,
                     input logic vp, input logic rd, input logic [23:0] ex,
                     input string tag);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; op_fetch = opf; vec_pull = vp; cpu_rd = rd;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
  endtask

  task automatic plain(input logic [23:0] a, input logic rd, input string tag);
    cyc(a, 8'h5A, 1'b0, 1'b0, rd, a, tag);
  endtask

  // Trap opcode, operand, then two stack writes that must pass through.
  task automatic arm(input logic [23:0] pc, input logic [7:0] num);
    cyc(pc, 8'h02, 1'b1, 1'b0, 1'b1, pc, "R8");
    cyc(pc + 24'd1, num, 1'b0, 1'b0, 1'b1, pc + 24'd1, "R2");
    plain(24'h0001FF, 1'b0, "R8");
    plain(24'h0001FE, 1'b0, "R8");
  endtask

  task automatic vpull(input logic [23:0] a, input logic [23:0] ex, input string tag);
    cyc(a, 8'h00, 1'b0, 1'b1, 1'b1, ex, tag);
  endtask

  // Monitor: compares each cycle's output shortly after inputs settle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [23:0] ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        checks++;
        if (mem_addr !== ex) begin
          errors++;
          $display("FAIL %s: mem_addr=%06h expected=%06h (cpu_addr=%06h)",
                   tg, mem_addr, ex, cpu_addr);
        end
      end
    end
  end

  initial begin
    // R1: pass-through while reset is held
    vpull(VN, VN, "R1");
    plain(24'h001234, 1'b1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing pending after reset
    vpull(VN, VN, "R1");
    vpull(VN + 24'd1, VN + 24'd1, "R1");

    // R10: unrelated opcode then read does not arm
    cyc(24'h002000, 8'hEA, 1'b1, 1'b0, 1'b1, 24'h002000, "R10");
    plain(24'h002001, 1'b1, "R10");
    vpull(VN, VN, "R10");

    // R2 R4 R5: number 0 through the native vector
    arm(24'h003000, 8'd0);
    vpull(VN, tbl_entry(0, 0), "R4");
    vpull(VN + 24'd1, tbl_entry(0, 1), "R5");
    vpull(VN, VN, "R5");

    // R4 R5: number 24 through the emulation vector
    arm(24'h003100, 8'd24);
    vpull(VE, tbl_entry(24, 0), "R4");
    vpull(VE + 24'd1, tbl_entry(24, 1), "R5");

    // R4 R5: largest number
    arm(24'h003200, 8'd255);
    vpull(VN, tbl_entry(255, 0), "R4");
    vpull(VN + 24'd1, tbl_entry(255, 1), "R5");

    // R6: foreign vector cancels
    arm(24'h003300, 8'd7);
    vpull(VIRQ, VIRQ, "R6");
    vpull(VIRQ + 24'd1, VIRQ + 24'd1, "R6");
    vpull(VN, VN, "R6");

    // R7: gap between low and high byte
    arm(24'h003400, 8'd3);
    vpull(VN, tbl_entry(3, 0), "R4");
    plain(24'h0001FD, 1'b1, "R7");
    vpull(VN + 24'd1, VN + 24'd1, "R7");
    // R7: high byte of the other flavour
    arm(24'h003500, 8'd4);
    vpull(VN, tbl_entry(4, 0), "R4");
    vpull(VE + 24'd1, VE + 24'd1, "R7");
    // R7: stray high byte with nothing pending
    vpull(VE + 24'd1, VE + 24'd1, "R7");

    // R3: write right after the opcode disarms
    cyc(24'h003600, 8'h02, 1'b1, 1'b0, 1'b1, 24'h003600, "R3");
    plain(24'h0001FF, 1'b0, "R3");
    vpull(VN, VN, "R3");

    // R9: unrelated opcode fetch cancels a held number
    arm(24'h003700, 8'd9);
    cyc(24'h003702, 8'hA9, 1'b1, 1'b0, 1'b1, 24'h003702, "R9");
    vpull(VN, VN, "R9");
    // R9: trap opcode again replaces the held number
    arm(24'h003800, 8'd9);
    arm(24'h003900, 8'h11);
    vpull(VE, tbl_entry(17, 0), "R9");
    vpull(VE + 24'd1, tbl_entry(17, 1), "R9");

    // R8: vector-less writes and reads at table and vector addresses
    plain(VN, 1'b0, "R8");
    plain(TBL, 1'b1, "R8");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule